// File: doc/BRIEF.md
# Serial-Bus Slave for Three Wiper Setting Registers

This block is an I2C-compatible slave that holds three 8-bit setting registers, one per resistor wiper. It oversamples SCL and SDA with a fast system clock, which must run at least 20 times the SCL rate, so both 100 kHz and 400 kHz buses work. It finds start, repeated start and stop conditions and shifts in address, command and data bytes MSB first. Each received byte that it accepts is acknowledged by pulling SDA low on the ninth clock.

A write transfer sends the address with R/W = 0, then a command byte that picks a channel, then one or more data bytes. In each data byte, bit 7 is a high-impedance flag and bits 6:0 are the wiper position. A read transfer first sends the command in a write phase, then a repeated start and the address with R/W = 1. The slave then returns the selected register. SDA is an active-high pull-down enable, so the slave never drives the line high.

The control FSM has these states: IDLE (bus free), ADDR (receiving the address), CMD (receiving the command), DATA (receiving data), ACK (holding the acknowledge), TX (sending a byte), RXACK (waiting for the master's acknowledge) and SKIP (ignoring the bus). A start moves the FSM from any state to ADDR, and a stop moves it from any state to IDLE. When ADDR has a full byte, a match goes to ACK and a mismatch goes to SKIP. A full byte in CMD goes to ACK if the command is valid and to SKIP if it is not. A full byte in DATA goes to ACK. On SCL falling, ACK moves on to CMD, DATA or TX. After eight bits, TX goes to RXACK. From RXACK, an ACK from the master returns to TX and a NACK goes to SKIP.

Top module: `wiper_i2c_slave`

## Requirements
- R1: The slave acknowledges the address byte {1010, 0, 0, dev_a0, R/W}, which is A0h/A1h when dev_a0 is 0 and A2h/A3h when dev_a0 is 1.
- R2: When the address does not match, the slave gives no ACK and ignores every later byte until the next start. The register outputs do not change.
- R3: The command bytes F8h, F9h and FAh select channel 0, 1 and 2, and each one is acknowledged.
- R4: Any other command byte gets a NACK. The following data bytes are ignored and the registers do not change.
- R5: A data byte written to channel n sets wiper_pos[n*7 +: 7] to bits 6:0 and wiper_hiz[n] to bit 7. The byte is acknowledged, and the update is visible by the ACK clock.
- R6: Further data bytes in the same write transfer overwrite the selected register again.
- R7: After a repeated start and a read address, the slave drives the selected register MSB first. When the master answers with NACK, the slave leaves SDA released until the stop. A read without a command in the same transfer returns the channel selected last.
- R8: A start aborts any byte in progress and restarts address reception. After a stop, bytes sent without a start are not acknowledged.
- R9: After reset, every register is 00h, channel 0 is selected and SDA is released.
- R10: The slave only pulls SDA low, and its SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_a0 | input | 1 | Address select pin, address bit 1 of the address byte |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| wiper_pos | output | 21 | Wiper positions, channel n at bits n*7 +: 7 |
| wiper_hiz | output | 3 | High-impedance flag per channel |

## Verification
On every cycle, the assertions check how the FSM responds to start and stop, that SDA stays released in IDLE and SKIP, that the SDA drive holds steady while SCL is high, and that registers change only as a data byte completes. Only the bench's bus scenarios can show the full behaviour. These cover address and command decoding, the ACK/NACK pattern seen on the wire, the bit order of read data, overwrite by several bytes, aborted bytes, and that nothing changes after a wrong address or an invalid command.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_CMD, S_DATA, S_ACK, S_TX, S_RXACK, S_SKIP
    } bus_state_t;

    // Command is valid when (b - base) falls inside the channel count
    function automatic logic cmd_hit(input logic [7:0] b, input logic [7:0] base,
                                     input int unsigned n);
        logic [7:0] d;
        d = b - base;
        return {24'd0, d} < n;
    endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_prev
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], d};
    end

    assign q      = chain[STAGES-1];
    assign q_prev = chain[STAGES];
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
    parameter int NCH   = 3,
    parameter int POS_W = 7,
    localparam int BYTE_W = POS_W + 1,
    localparam int SEL_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     sel,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [NCH*POS_W-1:0] pos_flat,
    output logic [NCH-1:0]       hiz_flat
);
    logic [BYTE_W-1:0] regs [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            regs[i] <= '0;
            else if (wr_en && sel == SEL_W'(i))    regs[i] <= wr_data;
        end
        assign pos_flat[i*POS_W +: POS_W] = regs[i][POS_W-1:0];
        assign hiz_flat[i]                = regs[i][POS_W];
    end

    assign rd_data = regs[sel];
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave #(
    parameter int         NCH      = 3,
    parameter int         POS_W    = 7,
    parameter logic [3:0] DEV_HIGH = 4'b1010,
    parameter logic [7:0] CMD_BASE = 8'hF8,
    localparam int BYTE_W = POS_W + 1,
    localparam int SEL_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dev_a0,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output logic                 sda_pull,
    output logic [NCH*POS_W-1:0] wiper_pos,
    output logic [NCH-1:0]       wiper_hiz
);
    import wiper_pkg::*;

    logic scl_s, scl_q, sda_s, sda_q;
    edge_sync #(.STAGES(2)) u_scl (.clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s), .q_prev(scl_q));
    edge_sync #(.STAGES(2)) u_sda (.clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s), .q_prev(sda_q));

    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

    bus_state_t        state, state_n, after_q, after_n;
    logic [7:0]        shreg, txsh;
    logic [3:0]        bitcnt;
    logic [SEL_W-1:0]  sel;
    logic [BYTE_W-1:0] rd_data;
    logic              byte_done, addr_ok, cmd_ok, wr_en;

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign addr_ok   = shreg[7:1] == {DEV_HIGH, 2'b00, dev_a0};
    assign cmd_ok    = cmd_hit(shreg, CMD_BASE, NCH);
    assign wr_en     = (state == S_DATA) && byte_done;

    wiper_bank #(.NCH(NCH), .POS_W(POS_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel),
        .wr_data(shreg[BYTE_W-1:0]), .rd_data(rd_data),
        .pos_flat(wiper_pos), .hiz_flat(wiper_hiz)
    );

    // Next-state logic
    always_comb begin
        state_n = state;
        after_n = after_q;
        if (start_det)      state_n = S_ADDR;
        else if (stop_det)  state_n = S_IDLE;
        else begin
            unique case (state)
                S_IDLE, S_SKIP: state_n = state;
                S_ADDR: if (byte_done) begin
                    state_n = addr_ok ? S_ACK : S_SKIP;
                    after_n = shreg[0] ? S_TX : S_CMD;
                end
                S_CMD: if (byte_done) begin
                    state_n = cmd_ok ? S_ACK : S_SKIP;
                    after_n = S_DATA;
                end
                S_DATA: if (byte_done) begin
                    state_n = S_ACK;
                    after_n = S_DATA;
                end
                S_ACK: if (scl_fall) state_n = after_q;
                S_TX: if (byte_done) state_n = S_RXACK;
                S_RXACK: begin
                    if (scl_rise && sda_s) state_n = S_SKIP;
                    else if (scl_fall)     state_n = S_TX;
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            after_q <= S_IDLE;
        end else begin
            state   <= state_n;
            after_q <= after_n;
        end
    end

    // Shift, counter, select and SDA drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0; txsh <= '0; bitcnt <= '0; sel <= '0; sda_pull <= 1'b0;
        end else if (start_det) begin
            bitcnt <= '0; sda_pull <= 1'b0;
        end else if (stop_det) begin
            bitcnt <= '0; sda_pull <= 1'b0;
        end else begin
            unique case (state)
                S_ADDR, S_CMD, S_DATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_done) begin
                        bitcnt   <= '0;
                        sda_pull <= (state_n == S_ACK);
                        if (state == S_CMD && cmd_ok) sel <= SEL_W'(shreg - CMD_BASE);
                    end
                end
                S_ACK: if (scl_fall) begin
                    bitcnt   <= '0;
                    sda_pull <= (after_q == S_TX) ? ~rd_data[BYTE_W-1] : 1'b0;
                    txsh     <= 8'(rd_data) << 1;
                end
                S_TX: begin
                    if (scl_rise) bitcnt <= bitcnt + 4'd1;
                    if (scl_fall) begin
                        if (bitcnt == 4'd8) sda_pull <= 1'b0;
                        else begin
                            sda_pull <= ~txsh[7];
                            txsh     <= txsh << 1;
                        end
                    end
                end
                S_RXACK: if (scl_fall && state_n == S_TX) begin
                    bitcnt   <= '0;
                    sda_pull <= ~rd_data[BYTE_W-1];
                    txsh     <= 8'(rd_data) << 1;
                end
                default: ;
            endcase
        end
    end

    // R8: start goes to address reception with SDA released
    a_r8_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_ADDR && !sda_pull));
    // R8: stop returns to idle
    a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == S_IDLE);
    // R2, R9: no drive while idle or ignoring the bus
    a_r2_quiet_when_skipping: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE || state == S_SKIP) |-> !sda_pull);
    // R10: drive never changes during an SCL high phase
    a_r10_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_pull));
    // R4, R5: settings change only as a data byte completes
    a_r5_update_only_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({wiper_pos, wiper_hiz}) |-> ($past(state) == S_DATA && state == S_ACK));
    // R5: bit counter bounded by one byte
    a_r5_bitcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd8);
endmodule

// File: tb/wiper_i2c_slave_test.sv
module wiper_i2c_slave_test;
    localparam int Q = 50;

    logic clk = 1'b0, rst_n = 1'b0, dev_a0 = 1'b0;
    logic scl_m = 1'b1, sda_low = 1'b0;
    logic sda_pull, sda_line;
    logic [20:0] wiper_pos;
    logic [2:0]  wiper_hiz;
    int tests = 0, fails = 0;
    logic [7:0] model [3];
    int msel = 0;

    always #2.5 clk = ~clk;
    assign sda_line = ~(sda_low | sda_pull);

    wiper_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .dev_a0(dev_a0), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .wiper_pos(wiper_pos), .wiper_hiz(wiper_hiz)
    );

    function automatic logic [7:0] addr_byte(input logic a0, input logic rw);
        return {4'b1010, 2'b00, a0, rw};
    endfunction
    function automatic logic cmd_valid(input logic [7:0] c);
        return c == 8'hF8 || c == 8'hF9 || c == 8'hFA;
    endfunction
    function automatic logic [23:0] exp_out();
        logic [23:0] r;
        for (int i = 0; i < 3; i++) begin
            r[i*7 +: 7] = model[i][6:0];
            r[21 + i]   = model[i][7];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask
    task automatic check_outs(input string req);
        check(req, {8'd0, wiper_hiz, wiper_pos}, {8'd0, exp_out()});
    endtask

    task automatic bus_start();
        sda_low = 1'b0; #Q; scl_m = 1'b1; #Q; sda_low = 1'b1; #Q; scl_m = 1'b0; #Q;
    endtask
    task automatic bus_stop();
        sda_low = 1'b1; #Q; scl_m = 1'b1; #Q; sda_low = 1'b0; #Q;
    endtask
    task automatic put_bit(input logic b);
        sda_low = ~b; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
    endtask
    task automatic get_bit(output logic b);
        sda_low = 1'b0; #Q; scl_m = 1'b1; #Q; b = sda_line; #Q; scl_m = 1'b0; #Q;
    endtask
    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask
    task automatic get_byte(output logic [7:0] v, input logic give_ack);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~give_ack);
    endtask

    task automatic do_write(input int ch, input logic [7:0] d, input int extra);
        logic ak; logic [7:0] d2;
        bus_start();
        put_byte(addr_byte(dev_a0, 1'b0), ak); check("R1 write address ACK", ak, 1);
        put_byte(8'hF8 + 8'(ch), ak);          check("R3 command ACK", ak, 1);
        msel = ch;
        put_byte(d, ak);                       check("R5 data ACK", ak, 1);
        model[ch] = d;
        check_outs("R5 setting outputs");
        for (int k = 0; k < extra; k++) begin
            d2 = 8'($urandom);
            put_byte(d2, ak); check("R6 extra byte ACK", ak, 1);
            model[ch] = d2;
            check_outs("R6 overwrite");
        end
        bus_stop();
    endtask

    task automatic do_read(input int ch, input logic with_cmd);
        logic ak; logic [7:0] v;
        bus_start();
        if (with_cmd) begin
            put_byte(addr_byte(dev_a0, 1'b0), ak); check("R1 address ACK", ak, 1);
            put_byte(8'hF8 + 8'(ch), ak);          check("R3 command ACK", ak, 1);
            msel = ch;
            bus_start();
        end
        put_byte(addr_byte(dev_a0, 1'b1), ak); check("R1 read address ACK", ak, 1);
        get_byte(v, 1'b0);
        check("R7 read data", v, model[msel]);
        check("R7 SDA released after NACK", sda_line, 1);
        bus_stop();
    endtask

    task automatic do_bad_addr();
        logic ak; logic [6:0] a;
        a = 7'($urandom_range(0, 127));
        if (a == {4'b1010, 2'b00, dev_a0}) a = a ^ 7'h10;
        bus_start();
        put_byte({a, 1'b0}, ak);      check("R2 foreign address NACK", ak, 0);
        put_byte(8'hF9, ak);          check("R2 command ignored", ak, 0);
        put_byte(8'($urandom), ak);   check("R2 data ignored", ak, 0);
        bus_stop();
        check_outs("R2 settings unchanged");
    endtask

    task automatic do_bad_cmd();
        logic ak; logic [7:0] c;
        c = 8'($urandom);
        if (cmd_valid(c)) c = 8'hFB;
        bus_start();
        put_byte(addr_byte(dev_a0, 1'b0), ak); check("R1 address ACK", ak, 1);
        put_byte(c, ak);                       check("R4 unknown command NACK", ak, 0);
        put_byte(8'($urandom), ak);            check("R4 data after bad command NACK", ak, 0);
        bus_stop();
        check_outs("R4 settings unchanged");
    endtask

    initial begin
        int unsigned seed;
        logic ak;
        seed = $urandom(32'd1234);
        for (int i = 0; i < 3; i++) model[i] = 8'h00;
        #21; rst_n = 1'b1; #(2*Q); #1;
        check("R9 reset outputs", {8'd0, wiper_hiz, wiper_pos}, 32'd0);
        check("R9 SDA released", sda_pull, 0);

        // Directed corners: min, max, high impedance, per channel
        do_write(0, 8'h00, 0);
        do_write(1, 8'h7F, 0);
        do_write(2, 8'h80, 0);
        do_read(1, 1'b1);
        do_read(2, 1'b0);
        do_write(0, 8'h55, 3);
        do_read(0, 1'b1);
        do_bad_cmd();
        do_bad_addr();

        // R8: start in mid-byte aborts it
        bus_start();
        put_byte(addr_byte(dev_a0, 1'b0), ak);
        put_byte(8'hF9, ak);
        msel = 1;
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_byte(addr_byte(dev_a0, 1'b0), ak); check("R8 restart address ACK", ak, 1);
        put_byte(8'hFA, ak);
        msel = 2;
        put_byte(8'h3C, ak); model[2] = 8'h3C;
        bus_stop();
        check_outs("R8 aborted byte left no trace");

        // R8: bytes after stop without start are ignored
        put_byte(addr_byte(dev_a0, 1'b0), ak); check("R8 no start no ACK", ak, 0);
        bus_stop();

        // R1: address pin moves the address
        dev_a0 = 1'b1; #Q;
        bus_start();
        put_byte(8'hA0, ak); check("R1 A0h NACK with pin high", ak, 0);
        bus_stop();
        do_write(1, 8'h12, 0);
        do_read(1, 1'b1);
        dev_a0 = 1'b0; #Q;

        // Random mix
        for (int n = 0; n < 40; n++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0, 1: do_write($urandom_range(0, 2), 8'($urandom), $urandom_range(0, 1));
                2:    do_read($urandom_range(0, 2), 1'b1);
                3:    do_bad_cmd();
                default: do_bad_addr();
            endcase
        end
        do_read(0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule